// File: doc/BRIEF.md
# Multi-Supply Reset Timeout Controller

This block is the digital core of a supervisor that watches four supply rails. It takes one synchronized "rail good" flag per rail, an active-low manual reset request, a one-cycle watchdog expiry pulse and a 2-bit timeout selector. From these it drives a single reset output whose polarity is chosen by a pin. Any rail fault asserts reset in the same cycle. Reset then stays asserted for one full timeout period after the last fault cause has gone away.

The timeout is counted in clock cycles. The parameter `CYC_PER_MS` gives the number of clock cycles per millisecond, so a simulation can shrink the periods. A manual reset request is accepted only after it has been held low for `MR_FILT` consecutive cycles, which rejects short glitches. A watchdog expiry produces a reset pulse of exactly one timeout period. After power-on reset the output starts asserted and runs one full period before it releases.

Top module: `supv_reset_ctrl`

## Requirements
- R1: When any bit of `rail_ok` is 0, the output is asserted in that same cycle.
- R2: Once all four rails are good and no other cause is active, the output stays asserted for exactly L cycles, counted from the first fault-free cycle, and is then released.
- R3: L = 50 · 2^`tsel` · `CYC_PER_MS` cycles. Code 0 gives 50 ms, 1 gives 100 ms, 2 gives 200 ms (the usual setting) and 3 gives 400 ms.
- R4: A low level on `mr_n` becomes a fault only in the (`MR_FILT`+1)-th consecutive low cycle, and stays a fault while `mr_n` remains low. A low run of `MR_FILT` cycles or fewer leaves the output unchanged.
- R5: After an accepted manual reset, `mr_n` returning high starts the L-cycle hold of R2 in that cycle.
- R6: A `wd_expire` pulse in cycle w asserts the output in cycles w+1 through w+L. If no other cause is present, the output is released in cycle w+L+1.
- R7: With `act_high` = 1 the output is 1 when asserted. With `act_high` = 0 it is 0 when asserted.
- R8: A fault cause or watchdog pulse that appears during the hold restarts the L-cycle count from zero once all causes are clear again.
- R9: While `rst_n` is low the output is asserted. After `rst_n` rises, the output stays asserted for L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low power-on reset |
| rail_ok | input | 4 | Per-rail supply-good flags, 1 = above threshold |
| mr_n | input | 1 | Active-low manual reset request |
| wd_expire | input | 1 | One-cycle watchdog expiry pulse |
| tsel | input | 2 | Timeout selector, see R3 |
| act_high | input | 1 | Output polarity, 1 = active-high |
| rst_out | output | 1 | Reset output |

## Verification
Two events can land in the same cycle: a watchdog pulse, and a rail or manual-reset fault that appears or clears. The case that matters most is a watchdog pulse arriving exactly in the cycle a rail recovers, or partway through a hold. Directed cases place these on chosen cycles, and random traffic makes them occur by chance. In every cycle the output is compared against a model built from the requirements, so a hold that comes out one cycle too long or too short is caught.

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
  parameter int CYC_PER_MS = 50000,
  parameter int MR_FILT    = 5,
  parameter int BASE_MS    = 50,
  parameter int N_RAIL     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_RAIL-1:0] rail_ok,
  input  logic              mr_n,
  input  logic              wd_expire,
  input  logic [1:0]        tsel,
  input  logic              act_high,
  output logic              rst_out
);
  localparam int MAX_CYC = BASE_MS * 8 * CYC_PER_MS;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int MRC_W   = $clog2(MR_FILT + 1);

  logic [CNT_W-1:0] cnt, lim;
  logic [MRC_W-1:0] mr_cnt;
  logic busy, mr_q, mr_hit, fault, asrt;

  assign lim    = CNT_W'(BASE_MS * CYC_PER_MS) << tsel;
  assign mr_hit = mr_q & ~mr_n;
  assign fault  = ~(&rail_ok) | mr_hit;
  assign asrt   = fault | busy;
  assign rst_out = act_high ? asrt : ~asrt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mr_cnt <= '0;
      mr_q   <= 1'b0;
    end else if (mr_n) begin
      mr_cnt <= '0;
      mr_q   <= 1'b0;
    end else begin
      if (mr_cnt != MRC_W'(MR_FILT - 1)) mr_cnt <= mr_cnt + 1'b1;
      if (mr_cnt == MRC_W'(MR_FILT - 1)) mr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (fault || wd_expire) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt >= lim - CNT_W'(1)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r1_rail_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !(&rail_ok) |=> (busy && cnt == '0));
  a_r2_hold_until_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fault && !wd_expire && cnt < lim - CNT_W'(1)) |=> busy);
  a_r4_mr_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_q) |-> $past(!mr_n));
  a_r5_mr_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mr_hit |=> busy);
  a_r6_wd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (busy && cnt == '0));
  a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&rail_ok)) |-> (rst_out == act_high));
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < lim || $changed(tsel));
endmodule

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb;
  localparam int CPM = 2;
  localparam int MRF = 4;

  logic clk = 0, rst_n = 0;
  logic [3:0] rail_ok = 4'hF;
  logic mr_n = 1, wd_expire = 0, act_high = 0;
  logic [1:0] tsel = 2'd0;
  logic rst_out;

  int vecs = 0, errs = 0;
  bit done = 0;
  string tag = "R9";

  bit hold; int q; int run;

  always #10 clk = ~clk;

  supv_reset_ctrl #(.CYC_PER_MS(CPM), .MR_FILT(MRF)) u_dut (
    .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .mr_n(mr_n),
    .wd_expire(wd_expire), .tsel(tsel), .act_high(act_high), .rst_out(rst_out));

  function automatic int lim_of(input logic [1:0] ts);
    return (50 * CPM) << ts;
  endfunction

  function automatic bit mr_acc(input logic m, input int r);
    return (!m) && (r >= MRF);
  endfunction

  task automatic step();
    bit f, exp_a;
    logic exp_o;
    #2;
    f = !(&rail_ok) || mr_acc(mr_n, run);
    exp_a = f || hold || !rst_n;
    exp_o = act_high ? exp_a : ~exp_a;
    vecs++;
    if (rst_out !== exp_o) begin
      errs++;
      $display("FAIL %s t=%0t rst_out=%b expected=%b", tag, $time, rst_out, exp_o);
    end
    if (!rst_n) begin hold = 1; q = 0; run = 0; end
    else begin
      if (f || wd_expire) begin hold = 1; q = 0; end
      else if (hold) begin q++; if (q >= lim_of(tsel)) begin hold = 0; q = 0; end end
      run = mr_n ? 0 : run + 1;
    end
    @(negedge clk);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic mr_pulse(input int len);
    mr_n = 0; cyc(len); mr_n = 1;
  endtask

  initial begin
    @(negedge clk);
    tag = "R9"; cyc(3); rst_n = 1; cyc(lim_of(0) + 5);
    tag = "R1"; rail_ok = 4'b1011; cyc(3);
    tag = "R2"; rail_ok = 4'hF; cyc(lim_of(0) + 3);
    tag = "R3";
    for (int t = 1; t < 4; t++) begin
      tsel = 2'(t); rail_ok = 4'b0111; cyc(2); rail_ok = 4'hF; cyc(lim_of(tsel) + 3);
    end
    tsel = 0;
    tag = "R4"; mr_pulse(MRF); cyc(6); mr_pulse(1); cyc(3); mr_pulse(MRF + 1); cyc(lim_of(0) + 4);
    tag = "R5"; mr_pulse(50); cyc(lim_of(0) + 4);
    tag = "R6"; wd_expire = 1; step(); wd_expire = 0; cyc(lim_of(0) + 4);
    tag = "R6"; rail_ok = 4'b1110; cyc(3); rail_ok = 4'hF; wd_expire = 1; step(); wd_expire = 0;
    cyc(lim_of(0) + 4);
    tag = "R8"; rail_ok = 4'b1101; cyc(2); rail_ok = 4'hF; cyc(40); rail_ok = 4'b1101; step();
    rail_ok = 4'hF; cyc(60); wd_expire = 1; step(); wd_expire = 0; cyc(lim_of(0) + 4);
    tag = "R7"; act_high = 1; rail_ok = 4'b0000; cyc(3); rail_ok = 4'hF; cyc(lim_of(0) + 3);
    tag = "R8";
    void'($urandom(32'd1234));
    for (int i = 0; i < 12000; i++) begin
      if ($urandom_range(0, 199) == 0) rail_ok = 4'($urandom);
      else if ($urandom_range(0, 9) == 0) rail_ok = 4'hF;
      if ($urandom_range(0, 149) == 0) mr_n = 0;
      else if (!mr_n && $urandom_range(0, 5) == 0) mr_n = 1;
      wd_expire = ($urandom_range(0, 399) == 0);
      if ($urandom_range(0, 999) == 0) act_high = ~act_high;
      if ($urandom_range(0, 1999) == 0 && !hold) tsel = 2'($urandom);
      step();
    end
    wd_expire = 0; mr_n = 1; rail_ok = 4'hF; cyc(lim_of(tsel) + 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog timeout expected=done actual=hung");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule